// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is an up-counting timer channel that sits idle until a qualified edge arrives on an external trigger input. That edge starts the counter from zero with no software action. The compare output then produces a pulse. The pulse begins after a programmable delay, set by the compare value, and ends when the count reaches the auto-reload value. The delay and the width are both measured in prescaled counter steps. With the one-shot bit set, the counter stops by itself at the rollover that follows, so exactly one pulse appears per trigger. With the bit clear, the counter keeps cycling and repeats the pulse each period.

A fast-start bit lets the output take its post-match level on the same clock edge that accepts the trigger. The comparison is skipped, which removes the startup delay. The bit acts only in the two PWM output modes.

Auto-reload and compare each have a shadow register. With preload on, writes land in the shadow copy. The shadow moves to the active copy on a software update strobe or at a counter rollover. The trigger polarity and the output polarity can each be inverted.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset, `running_o` is 0, `count_o` is 0 and `pulse_out` equals `cfg_out_inv`.
- R2: When `running_o` is 0, a qualified trigger edge sets `running_o` to 1 and the count to 0 at that same clock edge. The edge is a rising edge of `trig_in` when `cfg_trig_inv` is 0, and a falling edge when it is 1. Edges of the other direction start nothing.
- R3: With prescale value P, the count advances by one every P+1 clocks while running, and changes only by +1 or by wrapping to 0.
- R4: In mode 2'b10 (high after match) with fast-start off, call the trigger-accept edge cycle 0. The output reference is then high from cycle C*(P+1)+1 through cycle A*(P+1), where C is the compare value and A is the auto-reload value. When C >= A, no pulse appears.
- R5: When the count is at A and a prescaled step occurs, the count wraps to 0. If `cfg_one_shot` is 1, `running_o` clears at that edge, which is cycle (A+1)*(P+1). Otherwise counting continues with period (A+1)*(P+1).
- R6: With `cfg_fast` set in a PWM mode, the reference takes its post-match level in cycle 0 and keeps it until the count reaches A. The post-match level is 1 in mode 2'b10 and 0 in mode 2'b01. In the forced modes `cfg_fast` has no effect.
- R7: In mode 2'b01 (high before match) with fast-start off, the reference is high in cycles 1 through C*(P+1). The reference is 0 in both PWM modes whenever the counter is idle.
- R8: A trigger edge that arrives while `running_o` is 1 neither restarts nor alters the count.
- R9: `pulse_out` equals the reference XOR `cfg_out_inv`.
- R10: With `cfg_preload` at 0, a write takes effect at the next edge. With `cfg_preload` at 1, a write reaches the active value only at a `sw_update` pulse or at a counter rollover.
- R11: Mode 2'b00 holds the reference at 0 and mode 2'b11 holds it at 1, one clock after the mode is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | External trigger, already synchronous to clk |
| cfg_psc | input | PSC_W | Prescale value P (divide by P+1) |
| cfg_oc_mode | input | 2 | Output mode: 00 force low, 01 high before match, 10 high after match, 11 force high |
| cfg_fast | input | 1 | Fast-start enable |
| cfg_one_shot | input | 1 | Stop at rollover |
| cfg_out_inv | input | 1 | Output polarity inversion |
| cfg_trig_inv | input | 1 | Trigger polarity inversion |
| cfg_preload | input | 1 | Route writes through shadow registers |
| arr_we | input | 1 | Auto-reload write strobe |
| arr_wdata | input | CNT_W | Auto-reload write data |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| sw_update | input | 1 | Copy shadow values into active values |
| pulse_out | output | 1 | Compare output pin |
| running_o | output | 1 | Counter is enabled |
| count_o | output | CNT_W | Current count |

## Verification
On every cycle, the checker confirms several invariants:
- the counter only starts from a trigger edge, and starts at zero;
- the count only steps by one or wraps;
- a stop happens only at a wrap with one-shot set;
- an idle PWM channel and a forced channel drive the expected pin level.

The exact delay and width of the pulse under different prescale, compare and reload settings can only be shown by the bench's scenarios. The same holds for fast-start, ignored retriggers, trigger polarity and the timing of shadow transfers, because each needs a trigger history and a configured waveform to compare against.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  typedef enum logic [1:0] {
    OC_FORCE_LOW  = 2'b00,
    OC_PWM_EARLY  = 2'b01,
    OC_PWM_LATE   = 2'b10,
    OC_FORCE_HIGH = 2'b11
  } oc_mode_e;

  function automatic logic is_pwm(oc_mode_e m);
    return (m == OC_PWM_EARLY) || (m == OC_PWM_LATE);
  endfunction
endpackage

// File: rtl/tpt_trig_edge.sv
module tpt_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic invert,
  output logic edge_o
);
  logic lvl;
  logic lvl_q;

  assign lvl    = trig_in ^ invert;
  assign edge_o = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
endmodule

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_o = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q >= div) begin
        tick_o = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tpt_preload.sv
module tpt_preload #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         preload_en,
  input  logic         update,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] active_q, active_d;

  always_comb begin
    shadow_d = we ? wdata : shadow_q;
    if (we && !preload_en)  active_d = wdata;
    else if (update)        active_d = shadow_q;
    else                    active_d = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [1:0]       cfg_oc_mode,
  input  logic             cfg_fast,
  input  logic             cfg_one_shot,
  input  logic             cfg_out_inv,
  input  logic             cfg_trig_inv,
  input  logic             cfg_preload,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             sw_update,
  output logic             pulse_out,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o
);
  import tpt_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted asynchronously, released through a short synchronizer
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  oc_mode_e         mode;
  logic             trig_edge, start, tick, at_top, rollover, upd_evt;
  logic [CNT_W-1:0] arr_act, cmp_act;
  logic             run_q, run_d, fast_q, fast_d, ref_q, ref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             matched, in_window;

  assign mode = oc_mode_e'(cfg_oc_mode);

  tpt_trig_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .trig_in (trig_in),
    .invert  (cfg_trig_inv),
    .edge_o  (trig_edge)
  );

  assign start = trig_edge & ~run_q;

  tpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run_q),
    .restart (start),
    .div     (cfg_psc),
    .tick_o  (tick)
  );

  assign at_top   = (cnt_q >= arr_act);
  assign rollover = run_q & tick & at_top;
  assign upd_evt  = rollover | sw_update;

  tpt_preload #(.W(CNT_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .we         (arr_we),
    .wdata      (arr_wdata),
    .preload_en (cfg_preload),
    .update     (upd_evt),
    .active_o   (arr_act)
  );

  tpt_preload #(.W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .we         (cmp_we),
    .wdata      (cmp_wdata),
    .preload_en (cfg_preload),
    .update     (upd_evt),
    .active_o   (cmp_act)
  );

  // counter and enable next state
  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    fast_d = fast_q;
    if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      fast_d = cfg_fast & is_pwm(mode);
    end else if (run_q && tick) begin
      if (at_top) begin
        cnt_d  = '0;
        fast_d = 1'b0;
        if (cfg_one_shot) run_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // output reference next state
  assign matched   = fast_q | (cnt_q >= cmp_act);
  assign in_window = run_q & (cnt_q < arr_act);

  always_comb begin
    unique case (mode)
      OC_FORCE_LOW:  ref_d = 1'b0;
      OC_FORCE_HIGH: ref_d = 1'b1;
      OC_PWM_LATE:   ref_d = start ? cfg_fast : (in_window & matched);
      OC_PWM_EARLY:  ref_d = start ? 1'b0     : (in_window & ~matched);
      default:       ref_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      fast_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
      ref_q  <= ref_d;
    end
  end

  assign pulse_out = ref_q ^ cfg_out_inv;
  assign running_o = run_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_edge,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse_out,
  input logic             out_inv,
  input logic [1:0]       oc_mode,
  input logic             one_shot
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && !running) |=> (running && cnt == '0));

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $rose(running)) |-> $past(trig_edge));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && running && $past(running) && cnt != $past(cnt))
      |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(running)) |-> (cnt == '0 && $past(one_shot)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(!running && !trig_edge)
      && $past(oc_mode == 2'b01 || oc_mode == 2'b10)) |-> (pulse_out == out_inv));

  p_force_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(oc_mode) == 2'b11) |-> (pulse_out == !out_inv));

  p_force_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(oc_mode) == 2'b00) |-> (pulse_out == out_inv));
endmodule

bind trig_pulse_timer tpt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .trig_edge (trig_edge),
  .running   (running_o),
  .cnt       (count_o),
  .pulse_out (pulse_out),
  .out_inv   (cfg_out_inv),
  .oc_mode   (cfg_oc_mode),
  .one_shot  (cfg_one_shot)
);

// File: tb/trig_pulse_timer_tb_top.sv
module trig_pulse_timer_tb_top;
  localparam int CW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig_in;
  logic [PW-1:0] cfg_psc;
  logic [1:0]    cfg_oc_mode;
  logic          cfg_fast, cfg_one_shot, cfg_out_inv, cfg_trig_inv, cfg_preload;
  logic          arr_we, cmp_we, sw_update;
  logic [CW-1:0] arr_wdata, cmp_wdata;
  logic          pulse_out, running_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int errors = 0;
  logic trig_act = 1'b1;

  logic          ref_s [0:255];
  logic          raw_s [0:255];
  logic          run_s [0:255];
  logic [CW-1:0] cnt_s [0:255];
  int first_hi, last_hi, n_hi;

  always #5 clk = ~clk;

  trig_pulse_timer #(.CNT_W(CW), .PSC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_psc(cfg_psc),
    .cfg_oc_mode(cfg_oc_mode), .cfg_fast(cfg_fast), .cfg_one_shot(cfg_one_shot),
    .cfg_out_inv(cfg_out_inv), .cfg_trig_inv(cfg_trig_inv), .cfg_preload(cfg_preload),
    .arr_we(arr_we), .arr_wdata(arr_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .sw_update(sw_update), .pulse_out(pulse_out), .running_o(running_o), .count_o(count_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig_in = 1'b0; trig_act = 1'b1; cfg_psc = '0; cfg_oc_mode = 2'b10;
    cfg_fast = 0; cfg_one_shot = 1; cfg_out_inv = 0; cfg_trig_inv = 0; cfg_preload = 0;
    arr_we = 0; cmp_we = 0; sw_update = 0; arr_wdata = '0; cmp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input int psc, input logic [1:0] mode, input logic fast,
                     input logic one, input logic oinv);
    @(negedge clk);
    cfg_psc = PW'(psc); cfg_oc_mode = mode; cfg_fast = fast;
    cfg_one_shot = one; cfg_out_inv = oinv;
  endtask

  task automatic wr_arr(input int v);
    @(negedge clk); arr_we = 1'b1; arr_wdata = CW'(v);
    @(negedge clk); arr_we = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = CW'(v);
    @(negedge clk); cmp_we = 1'b0;
  endtask

  // trigger, then sample after each edge; index 0 = trigger-accept edge
  task automatic run_pulse(input int win, input int retrig_at);
    first_hi = -1; last_hi = -1; n_hi = 0;
    @(negedge clk); trig_in = trig_act;
    for (int j = 0; j < win; j++) begin
      @(negedge clk);
      ref_s[j] = pulse_out ^ cfg_out_inv;
      raw_s[j] = pulse_out;
      run_s[j] = running_o;
      cnt_s[j] = count_o;
      if (ref_s[j]) begin
        if (first_hi < 0) first_hi = j;
        last_hi = j;
        n_hi++;
      end
      if (j == 0) trig_in = ~trig_act;
      if (retrig_at > 0 && j == retrig_at - 1) trig_in = trig_act;
      if (retrig_at > 0 && j == retrig_at) trig_in = ~trig_act;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(running_o == 1'b0, "R1 running", running_o, 0);
    chk(count_o == '0, "R1 count", count_o, 0);
    chk(pulse_out == 1'b0, "R1 pulse", pulse_out, 0);
  endtask

  task automatic t_basic();
    do_reset(); cfg(0, 2'b10, 0, 1, 0); wr_arr(8); wr_cmp(3);
    run_pulse(14, 0);
    chk(run_s[0] && cnt_s[0] == 0, "R2 start", cnt_s[0], 0);
    chk(first_hi == 4, "R4 first", first_hi, 4);
    chk(last_hi == 8, "R4 last", last_hi, 8);
    chk(run_s[8] == 1'b1, "R5 still running", run_s[8], 1);
    chk(run_s[9] == 1'b0 && cnt_s[9] == 0, "R5 stop", run_s[9], 0);
  endtask

  task automatic t_prescale();
    do_reset(); cfg(2, 2'b10, 0, 1, 0); wr_arr(5); wr_cmp(2);
    run_pulse(22, 0);
    chk(cnt_s[2] == 0 && cnt_s[3] == 1, "R3 step", cnt_s[3], 1);
    chk(first_hi == 7 && last_hi == 15, "R4 prescaled first", first_hi, 7);
    chk(n_hi == 9, "R4 prescaled width", n_hi, 9);
    chk(run_s[17] && !run_s[18], "R5 prescaled stop", run_s[18], 0);
  endtask

  task automatic t_fast();
    do_reset(); cfg(1, 2'b10, 1, 1, 0); wr_arr(6); wr_cmp(4);
    run_pulse(18, 0);
    chk(first_hi == 0 && last_hi == 12, "R6 fast late", first_hi, 0);
    cfg(0, 2'b01, 1, 1, 0); wr_arr(6); wr_cmp(3);
    run_pulse(10, 0);
    chk(n_hi == 0, "R6 fast early level", n_hi, 0);
  endtask

  task automatic t_early();
    do_reset(); cfg(0, 2'b01, 0, 1, 0); wr_arr(6); wr_cmp(3);
    run_pulse(10, 0);
    chk(first_hi == 1 && last_hi == 3, "R7 early window", first_hi, 1);
    chk(ref_s[9] == 1'b0, "R7 idle low", ref_s[9], 0);
  endtask

  task automatic t_outinv();
    do_reset(); cfg(0, 2'b10, 0, 1, 1); wr_arr(4); wr_cmp(2);
    run_pulse(8, 0);
    chk(raw_s[0] == 1'b1, "R9 idle inverted", raw_s[0], 1);
    chk(raw_s[3] == 1'b0 && raw_s[4] == 1'b0, "R9 pulse inverted", raw_s[3], 0);
    chk(raw_s[5] == 1'b1, "R9 after pulse", raw_s[5], 1);
  endtask

  task automatic t_triginv();
    do_reset(); cfg(0, 2'b10, 0, 1, 0); wr_arr(3); wr_cmp(1);
    @(negedge clk); trig_in = 1'b1; cfg_trig_inv = 1'b1; trig_act = 1'b0;
    repeat (3) @(negedge clk);
    chk(running_o == 1'b0, "R2 rising ignored when inverted", running_o, 0);
    run_pulse(8, 0);
    chk(run_s[0] == 1'b1, "R2 falling starts", run_s[0], 1);
    repeat (3) @(negedge clk);
    chk(running_o == 1'b0, "R2 rise after run ignored", running_o, 0);
  endtask

  task automatic t_retrig();
    do_reset(); cfg(0, 2'b10, 0, 1, 0); wr_arr(10); wr_cmp(5);
    run_pulse(14, 3);
    chk(cnt_s[3] == 3, "R8 count kept", cnt_s[3], 3);
    chk(first_hi == 6 && last_hi == 10, "R8 pulse unchanged", first_hi, 6);
  endtask

  task automatic t_preload();
    do_reset(); cfg(0, 2'b10, 0, 1, 0); wr_arr(4); wr_cmp(2);
    @(negedge clk); cfg_preload = 1'b1;
    wr_cmp(1);
    run_pulse(8, 0);
    chk(first_hi == 3, "R10 shadow not active", first_hi, 3);
    run_pulse(8, 0);
    chk(first_hi == 2, "R10 rollover transfer", first_hi, 2);
    wr_cmp(3);
    @(negedge clk); sw_update = 1'b1;
    @(negedge clk); sw_update = 1'b0;
    run_pulse(8, 0);
    chk(first_hi == 4, "R10 update strobe", first_hi, 4);
  endtask

  task automatic t_forced();
    do_reset(); cfg(0, 2'b11, 0, 1, 0); wr_arr(4); wr_cmp(2);
    repeat (2) @(negedge clk);
    chk(pulse_out == 1'b1, "R11 force high", pulse_out, 1);
    cfg(0, 2'b00, 1, 1, 0);
    run_pulse(8, 0);
    chk(n_hi == 0, "R11 force low with fast", n_hi, 0);
  endtask

  task automatic t_no_pulse();
    do_reset(); cfg(0, 2'b10, 0, 1, 0); wr_arr(5); wr_cmp(5);
    run_pulse(9, 0);
    chk(n_hi == 0, "R4 cmp equals arr", n_hi, 0);
  endtask

  task automatic t_continuous();
    do_reset(); cfg(0, 2'b10, 0, 0, 0); wr_arr(3); wr_cmp(1);
    run_pulse(12, 0);
    chk(cnt_s[4] == 0 && run_s[4], "R5 wrap continues", cnt_s[4], 0);
    chk(ref_s[2] && ref_s[3] && !ref_s[4], "R5 first period", ref_s[4], 0);
    chk(ref_s[6] && ref_s[7] && run_s[11], "R5 repeat", ref_s[6], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_prescale();
    t_fast();
    t_early();
    t_outinv();
    t_triginv();
    t_retrig();
    t_preload();
    t_forced();
    t_no_pulse();
    t_continuous();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule